// File: doc/BRIEF.md
# Receive Interrupt Cause Controller

This block sits beside the receive path of a packet DMA engine and decides when the host should be interrupted about receive events. It derives the number of free receive descriptors from the head and tail pointers and a power-of-two ring size. It flags a low-descriptor event when that count first reaches a minimum, which is programmed as a fraction of the ring. It also flags an overrun when the packet FIFO is full at the moment a write is attempted, and it marks the rest of that packet for dropping.

Two delayed-interrupt timers are started by completed packets. The packet timer restarts on every good packet. The absolute timer starts only when it is idle. A low-descriptor or overrun event stops both timers, and they remain idle until the next good packet arrives.

All four events are latched in a cause register. Reading the register clears it. The register is gated by a mask to form one interrupt line.

Top module: `rx_irq_cause_ctrl`

## Requirements
- R1: `free_cnt` equals (head_ptr - tail_ptr - 1) modulo 2^L, where L is `ring_lg2` capped at 12. It follows its inputs in the same cycle.
- R2: The minimum equals 2^L shifted right by 1, 2, 3 or 1 for `thr_code` values 0, 1, 2 and 3 respectively. Code 3 is reserved and behaves as one half.
- R3: Cause bit 0 (low descriptors) is set by the clock edge that ends the first cycle in which `free_cnt` equals the minimum, after a cycle in which it did not. While the two stay equal, the bit is not raised again.
- R4: Cause bit 1 (overrun) is set by the edge that ends a cycle with `wr_try` and `fifo_full` both high, unless the current packet is already being dropped.
- R5: `drop_o` is high in the overrunning cycle and for every later write of that packet, up to and including the write marked `wr_last`. The next packet's writes see `drop_o` low.
- R6: A good packet end (`wr_try` and `wr_last` high, `drop_o` low) loads the packet timer with `delay_pkt` and restarts it if it is already running. Cause bit 2 is set D clock edges after the load edge, where a D of 0 acts as 1.
- R7: A good packet end loads the absolute timer with `delay_abs` only if that timer is idle. Cause bit 3 is set D edges after the load edge.
- R8: A low-descriptor or overrun event stops both timers without a timer cause. This takes priority over a packet end in the same cycle. The timers stay idle until a later good packet end.
- R9: `cause_rdata` shows the cause register. A cycle with `cause_rd` high clears the register at the next edge, but any cause set in that same cycle is kept.
- R10: `irq` is the OR of `cause_rdata & irq_mask`, and it follows the mask in the same cycle.
- R11: After reset the cause register is zero, `irq` and `drop_o` are low, and both timers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_lg2 | input | 4 | log2 of the ring size |
| head_ptr | input | 12 | Descriptor head pointer |
| tail_ptr | input | 12 | Descriptor tail pointer |
| thr_code | input | 2 | Minimum-fraction code |
| wr_try | input | 1 | FIFO write attempt |
| wr_last | input | 1 | Write is the last of its packet |
| fifo_full | input | 1 | Packet FIFO is full |
| delay_pkt | input | 16 | Packet timer reload value |
| delay_abs | input | 16 | Absolute timer reload value |
| irq_mask | input | 4 | Per-cause enable |
| cause_rd | input | 1 | Read strobe, clears causes |
| cause_rdata | output | 4 | Cause register value |
| irq | output | 1 | Interrupt line |
| drop_o | output | 1 | Current write belongs to a dropped packet |
| free_cnt | output | 12 | Free descriptor count |

## Verification
`free_cnt`, `drop_o` and `irq` are combinational, so they are checked in the same cycle as the input change that drives them. Low-descriptor and overrun causes appear one edge after the triggering cycle. Timer causes appear exactly D edges after the load edge, so the bench checks the cycle before as well as the due cycle. The driver makes every change at a falling edge, and it queues the expected value only after a short settle. The monitor compares queued items a few time units later in that same low phase, so each comparison lands after all registers on the path have updated.

// File: rtl/rxic_pkg.sv
package rxic_pkg;

  localparam int N_CAUSE = 4;
  localparam int N_TMR   = 2;

  typedef enum int {
    C_LOWDESC = 0,
    C_OVERRUN = 1,
    C_PKTTMR  = 2,
    C_ABSTMR  = 3
  } cause_e;

  // Free slots between tail and head in a ring of 2^lg entries.
  function automatic logic [31:0] ring_free(input logic [31:0] h,
                                            input logic [31:0] t,
                                            input logic [5:0]  lg);
    logic [31:0] msk;
    msk = (32'd1 << lg) - 32'd1;
    return (h - t - 32'd1) & msk;
  endfunction

  // Minimum level as a fraction of the ring; code 3 is reserved (half).
  function automatic logic [31:0] ring_floor(input logic [1:0] code,
                                             input logic [5:0] lg);
    logic [31:0] sz;
    int          sh;
    sz = 32'd1 << lg;
    case (code)
      2'd1:    sh = 2;
      2'd2:    sh = 3;
      default: sh = 1;
    endcase
    return sz >> sh;
  endfunction

endpackage

// File: rtl/rxic_ring_level.sv
module rxic_ring_level #(
  parameter int PTR_W = 12,
  parameter int LG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LG_W-1:0]  ring_lg2,
  input  logic [PTR_W-1:0] head_ptr,
  input  logic [PTR_W-1:0] tail_ptr,
  input  logic [1:0]       thr_code,
  output logic [PTR_W-1:0] free_cnt,
  output logic             low_evt
);
  import rxic_pkg::*;

  localparam logic [LG_W-1:0] LG_MAX = LG_W'(PTR_W);

  logic [LG_W-1:0] lg_eff;
  logic [31:0]     free_w;
  logic [31:0]     floor_w;
  logic            match_now;
  logic            match_q;

  always_comb begin
    lg_eff    = (ring_lg2 > LG_MAX) ? LG_MAX : ring_lg2;
    free_w    = ring_free(32'(head_ptr), 32'(tail_ptr), 6'(lg_eff));
    floor_w   = ring_floor(thr_code, 6'(lg_eff));
    match_now = (free_w == floor_w);
    free_cnt  = free_w[PTR_W-1:0];
    low_evt   = match_now && !match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_now;
  end

  AST_LOW_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> !low_evt); // R3

endmodule

// File: rtl/rxic_ovr_guard.sv
module rxic_ovr_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_try,
  input  logic wr_last,
  input  logic fifo_full,
  output logic ovr_evt,
  output logic drop_o,
  output logic pkt_ok
);
  logic drop_q;

  always_comb begin
    ovr_evt = wr_try && fifo_full && !drop_q;
    drop_o  = drop_q || ovr_evt;
    pkt_ok  = wr_try && wr_last && !drop_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q <= 1'b0;
    end else if (wr_try) begin
      if (wr_last)     drop_q <= 1'b0;
      else if (drop_o) drop_q <= 1'b1;
    end
  end

  AST_DROP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_o && wr_try && wr_last) |=> !drop_o || wr_try); // R5

endmodule

// File: rtl/rxic_delay_timer.sv
module rxic_delay_timer #(
  parameter int DLY_W   = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [DLY_W-1:0] dly,
  output logic             expire,
  output logic             running
);
  logic [DLY_W-1:0] cnt_q;
  logic             run_q;
  logic             may_load;

  always_comb begin
    expire   = run_q && (cnt_q <= DLY_W'(1)) && !cancel;
    may_load = start && (RESTART || !run_q || expire);
    running  = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cancel) begin
      run_q <= 1'b0;
    end else if (may_load) begin
      run_q <= 1'b1;
      cnt_q <= dly;
    end else if (expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !running); // R6

endmodule

// File: rtl/rxic_cause_reg.sv
module rxic_cause_reg #(
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] set_vec,
  input  logic          rd,
  input  logic [NC-1:0] mask,
  output logic [NC-1:0] cause_q,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= set_vec | (rd ? '0 : cause_q);
  end

  always_comb irq = |(cause_q & mask);

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (set_vec == '0)) |=> (cause_q == '0)); // R9

  for (genvar g = 0; g < NC; g++) begin : g_chk
    AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> cause_q[g]); // R9
  end

endmodule

// File: rtl/rx_irq_cause_ctrl.sv
module rx_irq_cause_ctrl #(
  parameter int PTR_W = 12,
  parameter int LG_W  = 4,
  parameter int DLY_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LG_W-1:0]              ring_lg2,
  input  logic [PTR_W-1:0]             head_ptr,
  input  logic [PTR_W-1:0]             tail_ptr,
  input  logic [1:0]                   thr_code,
  input  logic                         wr_try,
  input  logic                         wr_last,
  input  logic                         fifo_full,
  input  logic [DLY_W-1:0]             delay_pkt,
  input  logic [DLY_W-1:0]             delay_abs,
  input  logic [rxic_pkg::N_CAUSE-1:0] irq_mask,
  input  logic                         cause_rd,
  output logic [rxic_pkg::N_CAUSE-1:0] cause_rdata,
  output logic                         irq,
  output logic                         drop_o,
  output logic [PTR_W-1:0]             free_cnt
);
  import rxic_pkg::*;

  logic             low_evt;
  logic             ovr_evt;
  logic             pkt_ok;
  logic             tmr_cancel;
  logic [N_TMR-1:0] tmr_exp;
  logic [N_TMR-1:0] tmr_run;
  logic [N_CAUSE-1:0] set_vec;

  rxic_ring_level #(.PTR_W(PTR_W), .LG_W(LG_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .ring_lg2 (ring_lg2),
    .head_ptr (head_ptr),
    .tail_ptr (tail_ptr),
    .thr_code (thr_code),
    .free_cnt (free_cnt),
    .low_evt  (low_evt)
  );

  rxic_ovr_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_try    (wr_try),
    .wr_last   (wr_last),
    .fifo_full (fifo_full),
    .ovr_evt   (ovr_evt),
    .drop_o    (drop_o),
    .pkt_ok    (pkt_ok)
  );

  always_comb tmr_cancel = low_evt || ovr_evt;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    rxic_delay_timer #(.DLY_W(DLY_W), .RESTART(g == 0)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (pkt_ok),
      .cancel  (tmr_cancel),
      .dly     ((g == 0) ? delay_pkt : delay_abs),
      .expire  (tmr_exp[g]),
      .running (tmr_run[g])
    );
  end

  always_comb begin
    set_vec            = '0;
    set_vec[C_LOWDESC] = low_evt;
    set_vec[C_OVERRUN] = ovr_evt;
    set_vec[C_PKTTMR]  = tmr_exp[0];
    set_vec[C_ABSTMR]  = tmr_exp[1];
  end

  rxic_cause_reg #(.NC(N_CAUSE)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .rd      (cause_rd),
    .mask    (irq_mask),
    .cause_q (cause_rdata),
    .irq     (irq)
  );

  AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cancel |=> (tmr_run == '0)); // R8
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> cause_rdata[C_OVERRUN]); // R4
  AST_LOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> cause_rdata[C_LOWDESC]); // R3

endmodule

// File: tb/tb_rx_irq_cause_ctrl.sv
module tb_rx_irq_cause_ctrl;

  localparam int K_CAUSE = 0;
  localparam int K_IRQ   = 1;
  localparam int K_DROP  = 2;
  localparam int K_FREE  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ring_lg2 = 4'd4;
  logic [11:0] head_ptr = '0;
  logic [11:0] tail_ptr = '0;
  logic [1:0]  thr_code = '0;
  logic        wr_try = 1'b0;
  logic        wr_last = 1'b0;
  logic        fifo_full = 1'b0;
  logic [15:0] delay_pkt = 16'd10;
  logic [15:0] delay_abs = 16'd30;
  logic [3:0]  irq_mask = '0;
  logic        cause_rd = 1'b0;
  logic [3:0]  cause_rdata;
  logic        irq;
  logic        drop_o;
  logic [11:0] free_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  rx_irq_cause_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ring_lg2(ring_lg2), .head_ptr(head_ptr),
    .tail_ptr(tail_ptr), .thr_code(thr_code), .wr_try(wr_try),
    .wr_last(wr_last), .fifo_full(fifo_full), .delay_pkt(delay_pkt),
    .delay_abs(delay_abs), .irq_mask(irq_mask), .cause_rd(cause_rd),
    .cause_rdata(cause_rdata), .irq(irq), .drop_o(drop_o), .free_cnt(free_cnt)
  );

  function automatic logic [31:0] ref_free(int h, int t, int lg);
    int sz;
    sz = 1 << lg;
    return 32'(((h - t - 1) % sz + sz) % sz);
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic expect_out(int kind, logic [31:0] v, string req);
    item_t it;
    it.kind = kind;
    it.exp  = v;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic read_clear();
    cause_rd = 1'b1;
    step(1);
    cause_rd = 1'b0;
  endtask

  // Monitor: compare queued expectations late in the low phase.
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_CAUSE: act = 32'(cause_rdata);
          K_IRQ:   act = 32'(irq);
          K_DROP:  act = 32'(drop_o);
          default: act = 32'(free_cnt);
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    settle();
    // R11 reset state
    expect_out(K_CAUSE, 0, "R11");
    expect_out(K_IRQ, 0, "R11");
    expect_out(K_DROP, 0, "R11");
    expect_out(K_FREE, ref_free(0, 0, 4), "R1");

    step(1);
    head_ptr = 12'd5; tail_ptr = 12'd9;
    settle();
    expect_out(K_FREE, ref_free(5, 9, 4), "R1");
    step(1);
    ring_lg2 = 4'd6; head_ptr = 12'd3; tail_ptr = 12'd60;
    settle();
    expect_out(K_FREE, ref_free(3, 60, 6), "R1");
    step(1);
    ring_lg2 = 4'd15; head_ptr = 12'd100; tail_ptr = 12'd4000;
    settle();
    expect_out(K_FREE, ref_free(100, 4000, 12), "R1");
    step(1);
    ring_lg2 = 4'd4; head_ptr = 12'd0; tail_ptr = 12'd0;
    step(1);
    read_clear();

    // R3: code 0 -> minimum 8
    head_ptr = 12'd9;
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0001, "R3");
    expect_out(K_IRQ, 0, "R10");
    step(2);
    read_clear();
    step(2);
    settle();
    expect_out(K_CAUSE, 4'b0000, "R3");

    // R2: other codes
    head_ptr = 12'd0; thr_code = 2'd1;
    step(1);
    head_ptr = 12'd5;
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0001, "R2");
    read_clear();
    head_ptr = 12'd0; thr_code = 2'd2;
    step(1);
    head_ptr = 12'd3;
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0001, "R2");
    read_clear();
    head_ptr = 12'd0; thr_code = 2'd3;
    step(1);
    head_ptr = 12'd9;
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0001, "R2");
    read_clear();
    head_ptr = 12'd0;
    step(1);

    // R4/R5 overrun and drop
    wr_try = 1'b1; wr_last = 1'b0; fifo_full = 1'b0;
    settle();
    expect_out(K_DROP, 0, "R5");
    step(1);
    fifo_full = 1'b1;
    settle();
    expect_out(K_DROP, 1, "R5");
    step(1);
    fifo_full = 1'b0;
    settle();
    expect_out(K_DROP, 1, "R5");
    expect_out(K_CAUSE, 4'b0010, "R4");
    step(1);
    wr_last = 1'b1;
    settle();
    expect_out(K_DROP, 1, "R5");
    step(1);
    wr_last = 1'b0;
    settle();
    expect_out(K_DROP, 0, "R5");
    step(1);
    wr_try = 1'b0;

    // R9 read with a same-cycle set
    head_ptr = 12'd9; cause_rd = 1'b1;
    step(1);
    cause_rd = 1'b0;
    settle();
    expect_out(K_CAUSE, 4'b0001, "R9");
    step(1);
    head_ptr = 12'd0;
    read_clear();

    // R6/R7 timers
    wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    step(4);
    wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    step(9);
    settle();
    expect_out(K_CAUSE, 4'b0000, "R6");
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0100, "R6");
    step(14);
    settle();
    expect_out(K_CAUSE, 4'b0100, "R7");
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b1100, "R7");
    step(1);
    irq_mask = 4'b0100;
    settle();
    expect_out(K_IRQ, 1, "R10");
    step(1);
    irq_mask = 4'b0011;
    settle();
    expect_out(K_IRQ, 0, "R10");
    step(1);
    irq_mask = 4'b1000;
    settle();
    expect_out(K_IRQ, 1, "R10");
    step(1);
    irq_mask = 4'b0000;
    read_clear();

    // R8 overrun cancels running timers
    wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    step(2);
    wr_try = 1'b1; wr_last = 1'b1; fifo_full = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0; fifo_full = 1'b0;
    settle();
    expect_out(K_CAUSE, 4'b0010, "R8");
    step(40);
    settle();
    expect_out(K_CAUSE, 4'b0010, "R8");
    wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    step(9);
    settle();
    expect_out(K_CAUSE, 4'b0010, "R8");
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0110, "R8");
    read_clear();
    settle();
    expect_out(K_CAUSE, 4'b0000, "R9");

    // R8 low event beats packet end; running absolute timer stopped
    head_ptr = 12'd9; wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    settle();
    expect_out(K_CAUSE, 4'b0001, "R8");
    step(40);
    settle();
    expect_out(K_CAUSE, 4'b0001, "R8");
    head_ptr = 12'd0;
    read_clear();

    // R6 zero delay acts as one
    delay_pkt = 16'd0; delay_abs = 16'd20;
    wr_try = 1'b1; wr_last = 1'b1;
    step(1);
    wr_try = 1'b0; wr_last = 1'b0;
    settle();
    expect_out(K_CAUSE, 4'b0000, "R6");
    step(1);
    settle();
    expect_out(K_CAUSE, 4'b0100, "R6");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule